// File: doc/BRIEF.md
# Two-Way Set-Associative Read Cache

This block is a small read cache for a 16-bit machine whose physical memory is byte addressable and 14 bits wide. The CPU side presents a 16-bit address register value. The two top bits of that value are always zero and the cache ignores them. Both the set index and the tag come from the physical address. Each read looks up two direct-mapped ways of four entries in parallel. The block compares the stored tags, reports hit or miss, and returns one 16-bit word taken from the 8-byte line of the way that matched.

An external controller handles misses. It writes whole lines through a refill port, supplying only the address and the 64 line bits. The cache chooses the way itself. If the line is already present, the way that holds it is chosen. Otherwise the first empty way is chosen. Otherwise the block uses one least-recently-used bit kept per set. Writes from the CPU, write-back and the memory bus are handled elsewhere.

Top module: `rc_read_cache`

## Requirements
- R1: After a synchronous active-low reset every entry is invalid, `rd_valid` and `rd_hit` are low, and any read that follows misses until a refill is made.
- R2: The physical address is split as follows: bit 0 selects the byte in a word and is ignored, bits 2:1 select the word, bits 4:3 select the set, and bits 13:5 form a 9-bit tag. Bits 15:14 have no effect on the lookup.
- R3: A read request sampled at a clock edge produces `rd_valid` high, with its `rd_hit` and `rd_data`, on the following edge. In a cycle after an edge with no request, `rd_valid` is low.
- R4: A read hits when either way holds a valid entry in the addressed set whose tag equals the address tag. `rd_hit` is never high without `rd_valid`.
- R5: The word is selected little-endian: word k is line bits 16k+15 down to 16k, so word 0 is line bytes 1:0.
- R6: A refill whose tag is not present goes to way 0 if it is empty, else to way 1 if it is empty, else to the way the set's LRU bit names.
- R7: Every read hit and every refill marks the way it touched as most recently used in that set, so that the other way becomes the next victim.
- R8: A refill whose tag is already valid in one way of the set overwrites that way, so a tag never lives in both ways.
- R9: On a miss `rd_hit` is low and `rd_data` is zero.
- R10: When a read and a refill are issued in the same cycle, the read returns the contents held before the refill. If both address the same set, the refill's LRU update takes precedence.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rd_en | input | 1 | Read request |
| rd_addr | input | 16 | Read address (bits 15:14 ignored) |
| rd_valid | output | 1 | Registered: a read result is present |
| rd_hit | output | 1 | Registered: the read hit |
| rd_data | output | 16 | Registered: word read, zero on a miss |
| fill_en | input | 1 | Refill request |
| fill_addr | input | 16 | Address of the line being refilled |
| fill_line | input | 64 | Line contents, byte 0 in bits 7:0 |

## Verification
Several properties are checked on every cycle: the one-cycle result timing, a zero word on every miss, the fact that at most one way matches, and the LRU bit's state after each hit and each refill, including the case where a refill and a read hit the same set. Other behaviour is visible only in the bench's scenarios. These are the address field split, the little-endian word order, the replacement order across empty and full sets, overwriting a line that is already present, the read-before-refill ordering, and the loss of every line at reset.

// File: rtl/rc_pkg.sv
// Package rc_pkg
// Shared sizes and the physical address layout for the read cache.
// Assumes power-of-two word, line and set counts and exactly two ways.
package rc_pkg;
    localparam int ADDR_W     = 16;
    localparam int PADDR_W    = 14;
    localparam int BYTE_W     = 8;
    localparam int WORD_BYTES = 2;
    localparam int LINE_BYTES = 8;
    localparam int SETS       = 4;
    localparam int WAYS       = 2;

    localparam int WORD_W = WORD_BYTES * BYTE_W;
    localparam int LINE_W = LINE_BYTES * BYTE_W;
    localparam int WORDS  = LINE_BYTES / WORD_BYTES;
    localparam int BSEL_W = $clog2(WORD_BYTES);
    localparam int WSEL_W = $clog2(WORDS);
    localparam int IDX_W  = $clog2(SETS);
    localparam int TAG_W  = PADDR_W - IDX_W - WSEL_W - BSEL_W;

    typedef struct packed {
        logic [TAG_W-1:0]  tag;
        logic [IDX_W-1:0]  idx;
        logic [WSEL_W-1:0] wsel;
        logic [BSEL_W-1:0] bsel;
    } paddr_t;

    // Drop the always-zero upper bits and view the rest as fields.
    function automatic paddr_t split_addr(input logic [ADDR_W-1:0] a);
        return paddr_t'(a[PADDR_W-1:0]);
    endfunction
endpackage

// File: rtl/rc_way.sv
// Module rc_way
// One direct-mapped way: a valid bit, a tag and a line per set.
// It has two combinational lookup ports, one for reads and one for the refill side,
// and one synchronous write port. Only the valid bits are reset.
module rc_way
    import rc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [IDX_W-1:0]  lk_idx,
    input  logic [TAG_W-1:0]  lk_tag,
    output logic              lk_hit,
    output logic [LINE_W-1:0] lk_line,
    input  logic [IDX_W-1:0]  fl_idx,
    input  logic [TAG_W-1:0]  fl_tag,
    output logic              fl_match,
    output logic              fl_vld,
    input  logic              wr_en,
    input  logic [LINE_W-1:0] wr_line
);
    logic [SETS-1:0]   vld_q;
    logic [TAG_W-1:0]  tag_q  [SETS];
    logic [LINE_W-1:0] line_q [SETS];

    // Valid bits: cleared at reset, set by a write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld_q <= '0;
        end else if (wr_en) begin
            vld_q[fl_idx] <= 1'b1;
        end
    end

    // Tag and data storage: written on refill, never reset.
    always_ff @(posedge clk) begin
        if (wr_en) begin
            tag_q[fl_idx]  <= fl_tag;
            line_q[fl_idx] <= wr_line;
        end
    end

    // Read-side compare and line output.
    always_comb begin
        lk_hit  = vld_q[lk_idx] && (tag_q[lk_idx] == lk_tag);
        lk_line = line_q[lk_idx];
    end

    // Refill-side status: presence of the tag and occupancy of the set.
    always_comb begin
        fl_vld   = vld_q[fl_idx];
        fl_match = vld_q[fl_idx] && (tag_q[fl_idx] == fl_tag);
    end
endmodule

// File: rtl/rc_lru.sv
// Module rc_lru
// One LRU bit per set naming the least recently used way. It picks the
// refill victim in this order: a way already holding the tag, then the first empty way, then LRU.
// A refill update is written after a read update, so it wins on a shared set.
module rc_lru
    import rc_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rd_upd,
    input  logic [IDX_W-1:0] rd_idx,
    input  logic             rd_way,
    input  logic             fl_upd,
    input  logic [IDX_W-1:0] fl_idx,
    input  logic [WAYS-1:0]  fl_vld,
    input  logic [WAYS-1:0]  fl_match,
    output logic             fl_way,
    output logic [SETS-1:0]  lru_o
);
    logic [SETS-1:0] lru_q;

    // Victim choice for the refill address.
    always_comb begin
        if (|fl_match)      fl_way = fl_match[1];
        else if (!fl_vld[0]) fl_way = 1'b0;
        else if (!fl_vld[1]) fl_way = 1'b1;
        else                 fl_way = lru_q[fl_idx];
    end

    // LRU state: point at the way not just touched; the refill is written last.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lru_q <= '0;
        end else begin
            if (rd_upd) lru_q[rd_idx] <= ~rd_way;
            if (fl_upd) lru_q[fl_idx] <= ~fl_way;
        end
    end

    assign lru_o = lru_q;
endmodule

// File: rtl/rc_select.sv
// Module rc_select
// Combines the per-way compare results into one hit, encodes the hitting way,
// and muxes one little-endian word out of that way's line. It outputs zero when no way hits.
// Assumes at most one way hits.
module rc_select
    import rc_pkg::*;
(
    input  logic [WAYS-1:0]   way_hit,
    input  logic [LINE_W-1:0] way_line [WAYS],
    input  logic [WSEL_W-1:0] wsel,
    output logic              hit,
    output logic              hit_way,
    output logic [WORD_W-1:0] word
);
    logic [LINE_W-1:0] line_sel;

    // Hit reduction and way encoding.
    always_comb begin
        hit     = |way_hit;
        hit_way = way_hit[1];
    end

    // Way mux, then word mux; gated to zero on a miss.
    always_comb begin
        line_sel = way_line[hit_way];
        word     = hit ? line_sel[wsel*WORD_W +: WORD_W] : '0;
    end
endmodule

// File: rtl/rc_read_cache.sv
// Module rc_read_cache
// Top of the two-way, physically indexed and tagged read cache. It decodes
// both addresses, instantiates the ways, the LRU and the output selection, and registers the read result.
// The read result appears one cycle after the request. The refill writes on the clock edge it is sampled.
module rc_read_cache
    import rc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic              rd_valid,
    output logic              rd_hit,
    output logic [WORD_W-1:0] rd_data,
    input  logic              fill_en,
    input  logic [ADDR_W-1:0] fill_addr,
    input  logic [LINE_W-1:0] fill_line
);
    paddr_t            rd_pa;
    paddr_t            fl_pa;
    logic [WAYS-1:0]   way_hit;
    logic [LINE_W-1:0] way_line [WAYS];
    logic [WAYS-1:0]   fl_match;
    logic [WAYS-1:0]   fl_vld;
    logic              fill_way;
    logic [SETS-1:0]   lru_q;
    logic              hit;
    logic              hit_way;
    logic [WORD_W-1:0] word;
    logic              rd_valid_q;
    logic              rd_hit_q;
    logic [WORD_W-1:0] rd_data_q;

    // Field decode of both addresses.
    always_comb begin
        rd_pa = split_addr(rd_addr);
        fl_pa = split_addr(fill_addr);
    end

    for (genvar g = 0; g < WAYS; g++) begin : g_way
        rc_way u_way (
            .clk      (clk),
            .rst_n    (rst_n),
            .lk_idx   (rd_pa.idx),
            .lk_tag   (rd_pa.tag),
            .lk_hit   (way_hit[g]),
            .lk_line  (way_line[g]),
            .fl_idx   (fl_pa.idx),
            .fl_tag   (fl_pa.tag),
            .fl_match (fl_match[g]),
            .fl_vld   (fl_vld[g]),
            .wr_en    (fill_en && (fill_way == 1'(g))),
            .wr_line  (fill_line)
        );
    end

    rc_lru u_lru (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_upd   (rd_en && hit),
        .rd_idx   (rd_pa.idx),
        .rd_way   (hit_way),
        .fl_upd   (fill_en),
        .fl_idx   (fl_pa.idx),
        .fl_vld   (fl_vld),
        .fl_match (fl_match),
        .fl_way   (fill_way),
        .lru_o    (lru_q)
    );

    rc_select u_sel (
        .way_hit  (way_hit),
        .way_line (way_line),
        .wsel     (rd_pa.wsel),
        .hit      (hit),
        .hit_way  (hit_way),
        .word     (word)
    );

    // Result register: one cycle after the request, zero data on a miss.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_valid_q <= 1'b0;
            rd_hit_q   <= 1'b0;
            rd_data_q  <= '0;
        end else begin
            rd_valid_q <= rd_en;
            rd_hit_q   <= rd_en && hit;
            rd_data_q  <= (rd_en && hit) ? word : '0;
        end
    end

    assign rd_valid = rd_valid_q;
    assign rd_hit   = rd_hit_q;
    assign rd_data  = rd_data_q;
endmodule

// File: rtl/rc_checker.sv
// Module rc_checker
// Clocked properties on the read cache, attached to every instance of the top module by bind.
// It watches the ports and the per-way compare results, the victim choice and the LRU state.
module rc_checker
    import rc_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              rd_en,
    input logic [ADDR_W-1:0] rd_addr,
    input logic              rd_valid,
    input logic              rd_hit,
    input logic [WORD_W-1:0] rd_data,
    input logic              fill_en,
    input logic [ADDR_W-1:0] fill_addr,
    input logic [WAYS-1:0]   way_hit,
    input logic              fill_way,
    input logic [SETS-1:0]   lru_q
);
    logic [IDX_W-1:0] rd_idx;
    logic [IDX_W-1:0] fl_idx;
    assign rd_idx = rd_addr[BSEL_W+WSEL_W +: IDX_W];
    assign fl_idx = fill_addr[BSEL_W+WSEL_W +: IDX_W];

    p_valid_follows_req_r3: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |=> rd_valid);
    p_valid_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> !rd_valid);
    p_hit_needs_valid_r4: assert property (@(posedge clk) disable iff (!rst_n)
        rd_hit |-> rd_valid);
    p_miss_data_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid && !rd_hit) |-> (rd_data == '0));
    p_single_way_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(way_hit));
    p_lru_after_fill_r7: assert property (@(posedge clk) disable iff (!rst_n)
        fill_en |=> (lru_q[$past(fl_idx)] == !$past(fill_way)));
    p_lru_after_hit_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && (|way_hit) && !(fill_en && (fl_idx == rd_idx)))
        |=> (lru_q[$past(rd_idx)] == $past(way_hit[0])));
endmodule

bind rc_read_cache rc_checker u_rc_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .rd_en     (rd_en),
    .rd_addr   (rd_addr),
    .rd_valid  (rd_valid),
    .rd_hit    (rd_hit),
    .rd_data   (rd_data),
    .fill_en   (fill_en),
    .fill_addr (fill_addr),
    .way_hit   (way_hit),
    .fill_way  (fill_way),
    .lru_q     (lru_q)
);

// File: tb/test_rc_read_cache.sv
module test_rc_read_cache;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rd_en = 1'b0;
    logic [15:0] rd_addr = '0;
    logic        rd_valid;
    logic        rd_hit;
    logic [15:0] rd_data;
    logic        fill_en = 1'b0;
    logic [15:0] fill_addr = '0;
    logic [63:0] fill_line = '0;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    rc_read_cache i_rc_read_cache (
        .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .rd_addr(rd_addr),
        .rd_valid(rd_valid), .rd_hit(rd_hit), .rd_data(rd_data),
        .fill_en(fill_en), .fill_addr(fill_addr), .fill_line(fill_line)
    );

    localparam logic [63:0] L1 = 64'h4444_3333_2222_1111;
    localparam logic [63:0] L2 = 64'hDDDD_CCCC_BBBB_AAAA;
    localparam logic [63:0] L3 = 64'h8888_7777_6666_5555;
    localparam logic [63:0] L4 = 64'hF00D_BEEF_CAFE_0123;

    // {op (1 = refill), address, line, expected hit, expected word}
    localparam int NV = 14;
    localparam logic [97:0] VEC [NV] = '{
        {1'b1, 16'h0020, L1, 1'b0, 16'h0000},  // R6 way 0 empty
        {1'b0, 16'h0020, 64'h0, 1'b1, 16'h1111}, // R4 R5 word 0
        {1'b0, 16'h0026, 64'h0, 1'b1, 16'h4444}, // R5 word 3
        {1'b0, 16'h0023, 64'h0, 1'b1, 16'h2222}, // R2 byte bit ignored
        {1'b0, 16'hC020, 64'h0, 1'b1, 16'h1111}, // R2 upper bits ignored
        {1'b0, 16'h0040, 64'h0, 1'b0, 16'h0000}, // R9 miss
        {1'b1, 16'h0040, L2, 1'b0, 16'h0000},  // R6 way 1 empty
        {1'b0, 16'h0044, 64'h0, 1'b1, 16'hCCCC}, // R5 word 2
        {1'b0, 16'h0020, 64'h0, 1'b1, 16'h1111}, // R7 way 0 now recent
        {1'b1, 16'h0060, L3, 1'b0, 16'h0000},  // R6 R7 evicts tag 2
        {1'b0, 16'h0040, 64'h0, 1'b0, 16'h0000}, // R7 evicted line misses
        {1'b0, 16'h0020, 64'h0, 1'b1, 16'h1111}, // R7 kept line hits
        {1'b0, 16'h0062, 64'h0, 1'b1, 16'h6666}, // R4 new line word 1
        {1'b0, 16'h0028, 64'h0, 1'b0, 16'h0000}  // R2 same tag other set
    };

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic do_fill(input logic [15:0] a, input logic [63:0] l);
        fill_en = 1'b1; fill_addr = a; fill_line = l;
        step();
        fill_en = 1'b0;
    endtask

    task automatic do_read(input logic [15:0] a, input bit eh,
                           input logic [15:0] ed, input string req);
        rd_en = 1'b1; rd_addr = a;
        step();
        rd_en = 1'b0;
        chk(rd_valid == 1'b1, "R3", "rd_valid", 64'(rd_valid), 64'd1);
        chk(rd_hit == eh, req, "rd_hit", 64'(rd_hit), 64'(eh));
        chk(rd_data == ed, req, "rd_data", 64'(rd_data), 64'(ed));
    endtask

    task automatic do_both(input logic [15:0] ra, input logic [15:0] fa,
                           input logic [63:0] fl, input bit eh,
                           input logic [15:0] ed, input string req);
        rd_en = 1'b1; rd_addr = ra;
        fill_en = 1'b1; fill_addr = fa; fill_line = fl;
        step();
        rd_en = 1'b0; fill_en = 1'b0;
        chk(rd_hit == eh, req, "rd_hit", 64'(rd_hit), 64'(eh));
        chk(rd_data == ed, req, "rd_data", 64'(rd_data), 64'(ed));
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(rd_valid == 1'b0, "R1", "rd_valid in reset", 64'(rd_valid), 64'd0);
        chk(rd_hit == 1'b0, "R1", "rd_hit in reset", 64'(rd_hit), 64'd0);
        rst_n = 1'b1;
        step();
        chk(rd_valid == 1'b0, "R3", "rd_valid idle", 64'(rd_valid), 64'd0);
        do_read(16'h0020, 1'b0, 16'h0, "R1");

        for (int i = 0; i < NV; i++) begin
            if (VEC[i][97]) do_fill(VEC[i][96:81], VEC[i][80:17]);
            else do_read(VEC[i][96:81], VEC[i][16], VEC[i][15:0], $sformatf("R4 vec %0d", i));
        end
        step();
        chk(rd_valid == 1'b0, "R3", "rd_valid after idle", 64'(rd_valid), 64'd0);

        // R8: way 1 (tag 3) is LRU; refilling tag 1 must overwrite way 0.
        do_read(16'h0020, 1'b1, 16'h1111, "R8");
        do_fill(16'h0020, L4);
        do_read(16'h0062, 1'b1, 16'h6666, "R8");
        do_read(16'h0024, 1'b1, 16'hBEEF, "R8");

        // R10: set 2. The read hits way 1 while the refill refreshes way 0; the refill's LRU wins.
        do_fill(16'h0090, L1);
        do_fill(16'h00B0, L2);
        do_both(16'h00B0, 16'h0090, L3, 1'b1, 16'hAAAA, "R10");
        do_fill(16'h00D0, L4);
        do_read(16'h00B0, 1'b0, 16'h0000, "R10");
        do_read(16'h0090, 1'b1, 16'h5555, "R10");
        do_read(16'h00D6, 1'b1, 16'hF00D, "R6");

        // R10: a read of a line being refilled in the same cycle sees the old contents.
        do_both(16'h0018, 16'h0018, L2, 1'b0, 16'h0000, "R10");
        do_read(16'h001A, 1'b1, 16'hBBBB, "R10");

        // R1: a reset in mid-run drops every line.
        rst_n = 1'b0;
        step();
        rst_n = 1'b1;
        do_read(16'h0090, 1'b0, 16'h0000, "R1");
        do_read(16'h0018, 1'b0, 16'h0000, "R1");

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        #(5.0 * 20000);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule